// File: doc/BRIEF.md
# Radix-4 Booth Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a fixed-point signal-processing core. It multiplies two 17-bit signed operands in a single clock cycle. A modified radix-4 Booth recoder produces nine partial products. A carry-save chain of 3:2 compressors reduces them, and one carry-propagate adder closes the reduction into a 34-bit product. The product is sign-extended to 40 bits. It is then loaded into, added to or subtracted from one of two 40-bit accumulators.

Each accumulator has three fields: guard bits [39:32], a high half [31:16] and a low half [15:0]. The high half of accumulator A can be fed back as the multiplicand. This allows recursive computations such as repeated scaling or power series without a trip through memory. A square-and-accumulate operation multiplies the selected multiplicand by itself. Instruction decode, memory buses and the general ALU sit outside this block. They drive the operation code, the destination select and the operand source each cycle.

Top module: `booth_mac_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both accumulators to zero.
- R2: The product is the exact signed product of two 17-bit two's-complement operands, built from nine radix-4 Booth partial products. It covers the full range, including (-65536)*(-65536) = 2^32.
- R3: With `valid` high and `op` = 2'b00 (multiply-load), the destination accumulator takes the product sign-extended to 40 bits. The result appears on the accumulator output after the same rising edge that samples the request.
- R4: With `op` = 2'b01 (multiply-add), the sign-extended product is added to the destination accumulator. With `op` = 2'b10 (multiply-subtract), it is subtracted from it.
- R5: With `op` = 2'b11 (square-add), the selected multiplicand is multiplied by itself and the result is added to the destination. `y_in` has no effect on the result.
- R6: `dst_b` = 0 selects accumulator A as the destination and `dst_b` = 1 selects accumulator B. The other accumulator keeps its value.
- R7: With `valid` low, neither accumulator changes, whatever the other inputs carry.
- R8: With `src_acca` = 1, the multiplicand is bits [31:16] of accumulator A, read as a signed 16-bit value and sign-extended to 17 bits. `x_in` is then ignored.
- R9: Accumulation is modulo 2^40. Carries beyond bit 31 collect in the guard bits [39:32], and no saturation is applied: the value wraps past 2^39-1 into negative values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Request strobe; one operation per cycle while high |
| op | input | 2 | 00 multiply-load, 01 multiply-add, 10 multiply-subtract, 11 square-add |
| dst_b | input | 1 | Destination select: 0 = accumulator A, 1 = accumulator B |
| src_acca | input | 1 | 1 = take the multiplicand from accumulator A bits [31:16] |
| x_in | input | 17 | Multiplicand operand, signed |
| y_in | input | 17 | Multiplier operand, signed |
| acc_a | output | 40 | Accumulator A (guard, high, low fields) |
| acc_b | output | 40 | Accumulator B (guard, high, low fields) |

## Verification
A wrong Booth digit or a dropped compressor carry corrupts the product only for some operand bit patterns. Such an error shows on the destination accumulator one edge after the request, so it is caught in the same cycle it is issued. A wrong destination decode or a missing hold shows at once on the accumulator that should have stayed still. An error in the feedback path from accumulator A, or in the guard-bit carry, stays hidden until the value is reused or has grown past 32 bits. For that reason, long accumulation runs and feedback chains are compared after every step, not only at their end.

// File: rtl/booth_mac_pkg.sv
`timescale 1ns/1ps
package booth_mac_pkg;
  localparam int OPND_W = 17;
  localparam int ACC_W  = 40;

  typedef enum logic [1:0] {
    OP_MPY = 2'b00,
    OP_MAC = 2'b01,
    OP_MSU = 2'b10,
    OP_SQA = 2'b11
  } mac_op_e;

  // Radix-4 Booth digit from a three-bit window of the multiplier.
  function automatic logic signed [2:0] booth_digit(input logic [2:0] win);
    case (win)
      3'b001, 3'b010: return 3'sd1;
      3'b011:         return 3'sd2;
      3'b100:         return -3'sd2;
      3'b101, 3'b110: return -3'sd1;
      default:        return 3'sd0;
    endcase
  endfunction

  // Accumulator update for one operation; arithmetic wraps modulo 2^ACC_W.
  function automatic logic [ACC_W-1:0] acc_next(input mac_op_e op,
                                                input logic [ACC_W-1:0] acc,
                                                input logic [ACC_W-1:0] pext);
    case (op)
      OP_MPY:  return pext;
      OP_MSU:  return acc - pext;
      default: return acc + pext;
    endcase
  endfunction
endpackage

// File: rtl/booth_pp_gen.sv
`timescale 1ns/1ps
module booth_pp_gen #(
  parameter int OW  = 17,
  localparam int NPP = (OW + 1) / 2,
  localparam int PW  = 2 * OW,
  localparam int YW  = 2 * NPP + 1
) (
  input  logic [OW-1:0] mcand,
  input  logic [OW-1:0] mplier,
  output logic [PW-1:0] pp [NPP]
);
  import booth_mac_pkg::*;

  logic signed [YW-1:0] ywin;
  logic signed [PW-1:0] xs;
  assign ywin = $signed({mplier, 1'b0});
  assign xs   = $signed(mcand);

  for (genvar i = 0; i < NPP; i++) begin : g_pp
    logic signed [2:0]    dig;
    logic        [PW-1:0] mag;
    assign dig = booth_digit(ywin[2*i+2 -: 3]);
    always_comb begin
      case (dig)
        3'sd1:   mag = xs;
        3'sd2:   mag = xs <<< 1;
        -3'sd1:  mag = -xs;
        -3'sd2:  mag = -(xs <<< 1);
        default: mag = '0;
      endcase
    end
    assign pp[i] = mag << (2 * i);
  end
endmodule

// File: rtl/pp_reduce.sv
`timescale 1ns/1ps
module pp_reduce #(
  parameter int PW  = 34,
  parameter int NPP = 9
) (
  input  logic [PW-1:0] pp [NPP],
  output logic [PW-1:0] prod
);
  logic [PW-1:0] s [NPP-1];
  logic [PW-1:0] c [NPP-1];

  assign s[0] = pp[0];
  assign c[0] = pp[1];

  // Carry-save chain: each stage folds one more partial product in.
  for (genvar k = 1; k < NPP - 1; k++) begin : g_csa
    assign s[k] = s[k-1] ^ c[k-1] ^ pp[k+1];
    assign c[k] = ((s[k-1] & c[k-1]) | (s[k-1] & pp[k+1]) | (c[k-1] & pp[k+1])) << 1;
  end

  assign prod = s[NPP-2] + c[NPP-2];
endmodule

// File: rtl/acc_bank.sv
`timescale 1ns/1ps
module acc_bank #(
  parameter int ACC_W = 40,
  parameter int PW    = 34
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid,
  input  booth_mac_pkg::mac_op_e op,
  input  logic                  dst_b,
  input  logic [PW-1:0]         prod,
  output logic [ACC_W-1:0]      acc_a,
  output logic [ACC_W-1:0]      acc_b
);
  import booth_mac_pkg::*;

  logic [ACC_W-1:0] pext;
  logic [ACC_W-1:0] acc [2];
  assign pext = ACC_W'($signed(prod));

  for (genvar k = 0; k < 2; k++) begin : g_acc
    logic wr_en;
    assign wr_en = valid && (dst_b == 1'(k));
    always_ff @(posedge clk) begin
      if (rst)        acc[k] <= '0;
      else if (wr_en) acc[k] <= acc_next(op, acc[k], pext);
    end
  end

  assign acc_a = acc[0];
  assign acc_b = acc[1];

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (acc_a == '0) && (acc_b == '0));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(acc_a) && $stable(acc_b));
  a_r6_b_untouched: assert property (@(posedge clk) disable iff (rst)
    (valid && !dst_b) |=> $stable(acc_b));
  a_r6_a_untouched: assert property (@(posedge clk) disable iff (rst)
    (valid && dst_b) |=> $stable(acc_a));
  a_r3_load_a: assert property (@(posedge clk) disable iff (rst)
    (valid && !dst_b && op == OP_MPY) |=> acc_a == $past(pext));
  a_r4_sub_b: assert property (@(posedge clk) disable iff (rst)
    (valid && dst_b && op == OP_MSU) |=> acc_b == $past(acc_b) - $past(pext));
endmodule

// File: rtl/booth_mac_unit.sv
`timescale 1ns/1ps
module booth_mac_unit #(
  parameter int OW    = booth_mac_pkg::OPND_W,
  parameter int ACC_W = booth_mac_pkg::ACC_W,
  localparam int PW   = 2 * OW,
  localparam int NPP  = (OW + 1) / 2,
  localparam int HW   = OW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [1:0]       op,
  input  logic             dst_b,
  input  logic             src_acca,
  input  logic [OW-1:0]    x_in,
  input  logic [OW-1:0]    y_in,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b
);
  import booth_mac_pkg::*;

  mac_op_e       op_e;
  logic [OW-1:0] fb_opnd;
  logic [OW-1:0] mcand;
  logic [OW-1:0] mplier;
  logic [PW-1:0] pp [NPP];
  logic [PW-1:0] prod;

  assign op_e    = mac_op_e'(op);
  assign fb_opnd = {acc_a[2*HW-1], acc_a[2*HW-1:HW]};
  assign mcand   = src_acca ? fb_opnd : x_in;
  assign mplier  = (op_e == OP_SQA) ? mcand : y_in;

  booth_pp_gen #(.OW(OW)) u_ppgen (
    .mcand (mcand),
    .mplier(mplier),
    .pp    (pp)
  );

  pp_reduce #(.PW(PW), .NPP(NPP)) u_reduce (
    .pp  (pp),
    .prod(prod)
  );

  acc_bank #(.ACC_W(ACC_W), .PW(PW)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .valid(valid),
    .op   (op_e),
    .dst_b(dst_b),
    .prod (prod),
    .acc_a(acc_a),
    .acc_b(acc_b)
  );

  a_r2_product_exact: assert property (@(posedge clk) disable iff (rst)
    valid |-> $signed(prod) == $signed(mcand) * $signed(mplier));
  a_r5_square_nonneg: assert property (@(posedge clk) disable iff (rst)
    (valid && op_e == OP_SQA) |-> !prod[PW-1]);
endmodule

// File: tb/sim_booth_mac_unit.sv
`timescale 1ns/1ps
module sim_booth_mac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        dst_b = 1'b0;
  logic        src_acca = 1'b0;
  logic [16:0] x_in = '0;
  logic [16:0] y_in = '0;
  logic [39:0] acc_a, acc_b;

  always #10 clk = ~clk;

  booth_mac_unit u0 (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .dst_b(dst_b),
    .src_acca(src_acca), .x_in(x_in), .y_in(y_in), .acc_a(acc_a), .acc_b(acc_b)
  );

  logic [39:0] ma = '0, mb = '0;
  logic [79:0] q_exp [$];
  string       q_tag [$];
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // Scoreboard monitor: compare each expected pair just after its edge.
  initial forever begin
    @(posedge clk);
    #2;
    if (q_exp.size() > 0) begin
      logic [79:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_vec++;
      if ({acc_a, acc_b} !== e) begin
        n_bad++;
        $display("FAIL %s: acc_a=%h acc_b=%h expected acc_a=%h acc_b=%h",
                 t, acc_a, acc_b, e[79:40], e[39:0]);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; valid = 1'b0;
    ma = '0; mb = '0;
    q_exp.push_back({ma, mb}); q_tag.push_back("R1 reset");
  endtask

  task automatic issue(input bit v, input logic [1:0] o, input bit d, input bit sa,
                       input logic [16:0] x, input logic [16:0] y, input string tag);
    longint mx, my, pr;
    logic [39:0] pe, cur;
    @(negedge clk);
    rst = 1'b0; valid = v; op = o; dst_b = d; src_acca = sa; x_in = x; y_in = y;
    mx = sa ? longint'($signed(ma[31:16])) : longint'($signed(x));
    my = (o == 2'b11) ? mx : longint'($signed(y));
    pr = mx * my;
    pe = pr[39:0];
    if (v) begin
      cur = d ? mb : ma;
      if (o == 2'b00)      cur = pe;
      else if (o == 2'b10) cur = cur - pe;
      else                 cur = cur + pe;
      if (d) mb = cur; else ma = cur;
    end
    q_exp.push_back({ma, mb}); q_tag.push_back(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    do_reset();
    // R2/R3 loads with distinct patterns and extremes
    issue(1, 2'b00, 0, 0, 17'd3,      17'd5,      "R3 load A small");
    issue(1, 2'b00, 1, 0, 17'h1FFFF,  17'd7,      "R2 load B neg*pos");
    issue(1, 2'b00, 0, 0, 17'h10000,  17'h10000,  "R2 min*min = 2^32");
    issue(1, 2'b00, 1, 0, 17'h0FFFF,  17'h10000,  "R2 max*min");
    issue(1, 2'b00, 0, 0, 17'h0AAAA,  17'h15555,  "R2 alternating bits");
    // R4 add / subtract
    issue(1, 2'b01, 0, 0, 17'd1000,   17'h1FC18,  "R4 mac A");
    issue(1, 2'b10, 1, 0, 17'd12345,  17'd321,    "R4 msu B");
    issue(1, 2'b10, 1, 0, 17'h18000,  17'h0FFFF,  "R4 msu B neg product");
    // R7 idle with garbage
    issue(0, 2'b00, 0, 1, 17'h1ABCD,  17'h0F0F0,  "R7 idle A");
    issue(0, 2'b11, 1, 0, 17'h0FFFF,  17'h0FFFF,  "R7 idle B");
    // R5 square-add ignores y_in
    issue(1, 2'b11, 0, 0, 17'h1FF00,  17'h0DEAD,  "R5 square A");
    issue(1, 2'b11, 1, 0, 17'd300,    17'h1BEEF,  "R5 square B");
    // R8 feedback of acc A high field, x_in ignored
    issue(1, 2'b00, 0, 0, 17'h00400,  17'h00100,  "R3 preload A");
    issue(1, 2'b00, 1, 1, 17'h1FFFF,  17'd3,      "R8 fb pos into B");
    issue(1, 2'b00, 0, 0, 17'h1FC00,  17'h00100,  "R3 preload A neg");
    issue(1, 2'b01, 1, 1, 17'h05555,  17'd5,      "R8 fb neg into B");
    issue(1, 2'b11, 0, 1, 17'h12345,  17'h00777,  "R8 R5 fb square A");
    // R9 guard growth and wrap
    do_reset();
    for (int i = 0; i < 128; i++)
      issue(1, 2'b11, 0, 0, 17'h10000, 17'd0, "R9 guard growth");
    for (int i = 0; i < 128; i++)
      issue(1, 2'b11, 0, 0, 17'h10000, 17'd0, "R9 wrap to zero");
    issue(1, 2'b10, 1, 0, 17'd1, 17'd1, "R9 wrap below zero");
    // Mixed pseudo-random stream
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r1, r2;
      lfsr = step(lfsr); r1 = lfsr;
      lfsr = step(lfsr); r2 = lfsr;
      issue(r1[31] | r1[30], r1[1:0], r1[2], r1[3] & r1[4], r1[21:5], r2[16:0],
            "R2 R4 R6 mixed");
    end
    do_reset();
    issue(0, 2'b01, 1, 0, 17'd9, 17'd9, "R1 R7 post-reset idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule